// File: doc/BRIEF.md
# ATM Cell Delineation by Header Check

This block finds ATM cell boundaries in a received byte stream. For each candidate header it computes the header error control value over four header bytes and compares it with the byte that follows. The block starts in a hunting state and tests every byte position. It then moves to a pre-lock state, where it checks only at 53-byte spacing. From there it reaches lock. Once locked, it stays locked until enough consecutive bad headers arrive.

The counts that decide both transitions come from an 8-bit threshold register. The upper nibble sets the number of consecutive bad headers that drop lock. The lower nibble sets the number of consecutive good headers needed to gain lock. A write-protect input can freeze the register. The block outputs a lock flag and two one-cycle pulses: one marks each header boundary while locked, the other marks each bad header found at a checked boundary.

Top module: `cell_delin`

## Requirements
- R1: The check value is the CRC-8 of the four header bytes, taken first byte first and MSB first, with polynomial x^8+x^2+x+1 (0x07) and initial value 0, XORed with 0x55. A header is correct when this equals the fifth byte.
- R2: After reset the threshold register reads 0x78 on `cfg_rdata_o`. Bits [7:4] are the loss count and bits [3:0] are the gain count, so the defaults are 7 and 8.
- R3: When `cfg_we_i`=1 and `cfg_lock_i`=0, `cfg_wdata_i` is loaded and visible on the next cycle. When `cfg_lock_i`=1, a write leaves the register unchanged.
- R4: In the hunt state, every accepted byte that has at least four accepted bytes before it since reset is tested as a fifth header byte. The first match enters pre-lock. Mismatches in hunt produce no `hec_err_o` pulse.
- R5: In pre-lock and lock, a header is checked only on the byte that is 53 accepted bytes after the previous checked fifth byte. A bad header in pre-lock returns the block to hunt and pulses `hec_err_o`.
- R6: From pre-lock, lock is gained when the gain count of further consecutive correct headers is reached. `locked_o` rises in the cycle after that header's fifth byte is accepted.
- R7: While locked, `locked_o` falls in the cycle after the fifth byte of the loss-count-th consecutive bad header.
- R8: A correct header while locked clears the consecutive bad-header count.
- R9: A threshold field of 0 acts as 1.
- R10: `cell_start_o` pulses for one cycle after each checked fifth byte, good or bad, that is accepted while already locked. It does not pulse on the header that gains lock.
- R11: `hec_err_o` pulses for one cycle after each checked fifth byte that is incorrect in pre-lock or lock.
- R12: A byte presented with `valid_i`=0 is ignored. It does not shift the header window or advance the cell position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_i | input | 8 | Received byte |
| valid_i | input | 1 | byte_i is valid this cycle |
| cfg_we_i | input | 1 | Threshold register write strobe |
| cfg_wdata_i | input | 8 | Threshold write data |
| cfg_lock_i | input | 1 | Write protect for the threshold register |
| cfg_rdata_o | output | 8 | Threshold register contents |
| locked_o | output | 1 | Cell delineation locked |
| cell_start_o | output | 1 | Header boundary pulse while locked |
| hec_err_o | output | 1 | Bad header pulse at a checked boundary |

## Verification
The bench checks how many cells it takes to gain lock. With default thresholds this is the ninth cell; with a gain count of 2 it is the third. A design that counted the hunt match as one of the gain headers, or that needed one cell too many, would lock a cell early or late. The bench also interleaves a good header between runs of bad ones to catch a design that keeps its bad-header count after a good header (it would drop lock early), and it sends a bad header in pre-lock, which must return the block to hunt. Finally it sets zero thresholds, which must act as 1, and inserts idle cycles carrying garbage bytes, which must not shift the cell position.

// File: rtl/cell_delin_pkg.sv
package cell_delin_pkg;
  localparam int unsigned HDR_BYTES = 4;
  localparam logic [7:0] HEC_POLY  = 8'h07;
  localparam logic [7:0] HEC_COSET = 8'h55;

  typedef enum logic [1:0] {ST_HUNT, ST_PRESYNC, ST_SYNC} dl_state_e;

  function automatic logic [7:0] hec_of(input logic [8*HDR_BYTES-1:0] hdr);
    logic [7:0] c;
    c = '0;
    for (int i = 8*HDR_BYTES-1; i >= 0; i--) begin
      c = {c[6:0], 1'b0} ^ ((c[7] ^ hdr[i]) ? HEC_POLY : 8'h00);
    end
    return c ^ HEC_COSET;
  endfunction
endpackage

// File: rtl/cd_thresh_reg.sv
module cd_thresh_reg #(
  parameter int unsigned FIELD_W = 4,
  parameter logic [2*FIELD_W-1:0] RST_VAL = 8'h78,
  localparam int unsigned REG_W = 2*FIELD_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic               lock_i,
  input  logic [REG_W-1:0]   wdata_i,
  output logic [REG_W-1:0]   q_o,
  output logic [FIELD_W-1:0] gain_o,
  output logic [FIELD_W-1:0] loss_o
);
  logic [REG_W-1:0]   q;
  logic [FIELD_W-1:0] eff [2];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              q <= RST_VAL;
    else if (we_i && !lock_i) q <= wdata_i;
  end

  // zero field acts as one
  for (genvar g = 0; g < 2; g++) begin : g_clamp
    assign eff[g] = (q[g*FIELD_W +: FIELD_W] == '0) ? FIELD_W'(1) : q[g*FIELD_W +: FIELD_W];
  end

  assign q_o    = q;
  assign gain_o = eff[0];
  assign loss_o = eff[1];

  AST_WRITE_PROTECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && lock_i) |=> $stable(q_o)); // R3
  AST_WRITE_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !lock_i) |=> (q_o == $past(wdata_i))); // R3
endmodule

// File: rtl/cd_hec_window.sv
module cd_hec_window
  import cell_delin_pkg::*;
#(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned FILL_W = $clog2(HDR_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  output logic              match_o
);
  logic [HDR_BYTES-1:0][BYTE_W-1:0] hist_q; // [HDR_BYTES-1] oldest
  logic [FILL_W-1:0]                fill_q;
  logic                             filled;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (valid_i) begin
      hist_q <= {hist_q[HDR_BYTES-2:0], byte_i};
      if (!filled) fill_q <= fill_q + 1'b1;
    end
  end

  assign filled  = (fill_q == FILL_W'(HDR_BYTES));
  assign match_o = filled && (hec_of(hist_q) == byte_i);
endmodule

// File: rtl/cd_delin_fsm.sv
module cd_delin_fsm
  import cell_delin_pkg::*;
#(
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned CNT_W    = 4,
  localparam int unsigned POS_W   = $clog2(CELL_LEN)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             match_i,
  input  logic [CNT_W-1:0] gain_i,
  input  logic [CNT_W-1:0] loss_i,
  output logic             locked_o,
  output logic             cell_start_o,
  output logic             hec_err_o
);
  dl_state_e        state_q;
  logic [POS_W-1:0] pos_q;
  logic [CNT_W-1:0] good_q, bad_q;
  logic [CNT_W:0]   good_inc, bad_inc;
  logic             at_bnd;
  logic             start_q, err_q;

  assign at_bnd   = (pos_q == POS_W'(CELL_LEN - 1));
  assign good_inc = {1'b0, good_q} + 1'b1;
  assign bad_inc  = {1'b0, bad_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_HUNT;
      pos_q   <= '0;
      good_q  <= '0;
      bad_q   <= '0;
      start_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      start_q <= 1'b0;
      err_q   <= 1'b0;
      if (valid_i) begin
        unique case (state_q)
          ST_HUNT: begin
            if (match_i) begin
              state_q <= ST_PRESYNC;
              pos_q   <= '0;
              good_q  <= '0;
            end
          end
          ST_PRESYNC: begin
            if (!at_bnd) pos_q <= pos_q + 1'b1;
            else begin
              pos_q <= '0;
              if (!match_i) begin
                state_q <= ST_HUNT;
                err_q   <= 1'b1;
              end else if (good_inc >= {1'b0, gain_i}) begin
                state_q <= ST_SYNC;
                bad_q   <= '0;
              end else begin
                good_q <= good_inc[CNT_W-1:0];
              end
            end
          end
          ST_SYNC: begin
            if (!at_bnd) pos_q <= pos_q + 1'b1;
            else begin
              pos_q   <= '0;
              start_q <= 1'b1;
              if (match_i) bad_q <= '0;
              else begin
                err_q <= 1'b1;
                if (bad_inc >= {1'b0, loss_i}) begin
                  state_q <= ST_HUNT;
                  bad_q   <= '0;
                end else begin
                  bad_q <= bad_inc[CNT_W-1:0];
                end
              end
            end
          end
          default: state_q <= ST_HUNT;
        endcase
      end
    end
  end

  assign locked_o     = (state_q == ST_SYNC);
  assign cell_start_o = start_q;
  assign hec_err_o    = err_q;

  AST_HUNT_NO_DIRECT_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT) |=> (state_q != ST_SYNC)); // R6
  AST_HUNT_NO_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_HUNT) |=> !hec_err_o); // R4
  AST_PRESYNC_ERR_TO_HUNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_PRESYNC && valid_i && at_bnd && !match_i) |=> (state_q == ST_HUNT && hec_err_o)); // R5
  AST_SYNC_GOOD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SYNC && valid_i && at_bnd && match_i) |=> (bad_q == '0 && locked_o)); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(pos_q) && $stable(state_q))); // R12
  AST_START_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cell_start_o |=> !cell_start_o); // R10
  AST_ERR_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hec_err_o |=> !hec_err_o); // R11
endmodule

// File: rtl/cell_delin.sv
module cell_delin #(
  parameter int unsigned BYTE_W   = 8,
  parameter int unsigned CELL_LEN = 53,
  parameter int unsigned FIELD_W  = 4,
  parameter logic [2*FIELD_W-1:0] THR_RST = 8'h78,
  localparam int unsigned REG_W = 2*FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              valid_i,
  input  logic              cfg_we_i,
  input  logic [REG_W-1:0]  cfg_wdata_i,
  input  logic              cfg_lock_i,
  output logic [REG_W-1:0]  cfg_rdata_o,
  output logic              locked_o,
  output logic              cell_start_o,
  output logic              hec_err_o
);
  logic [FIELD_W-1:0] gain, loss;
  logic               match;

  cd_thresh_reg #(.FIELD_W(FIELD_W), .RST_VAL(THR_RST)) u_thr (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(cfg_we_i), .lock_i(cfg_lock_i),
    .wdata_i(cfg_wdata_i), .q_o(cfg_rdata_o), .gain_o(gain), .loss_o(loss)
  );

  cd_hec_window #(.BYTE_W(BYTE_W)) u_win (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .valid_i(valid_i), .match_o(match)
  );

  cd_delin_fsm #(.CELL_LEN(CELL_LEN), .CNT_W(FIELD_W)) u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .match_i(match),
    .gain_i(gain), .loss_i(loss), .locked_o(locked_o),
    .cell_start_o(cell_start_o), .hec_err_o(hec_err_o)
  );
endmodule

// File: tb/cell_delin_bench.sv
module cell_delin_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 5;
  // {we, lock, wdata[7:0], expected rdata[7:0]}
  localparam logic [17:0] CFG_VEC [NVEC] = '{
    {1'b1, 1'b0, 8'h32, 8'h32},
    {1'b1, 1'b1, 8'hFF, 8'h32},
    {1'b0, 1'b0, 8'h11, 8'h32},
    {1'b1, 1'b0, 8'h23, 8'h23},
    {1'b1, 1'b0, 8'h32, 8'h32}
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       valid_i = 1'b0;
  logic       cfg_we_i = 1'b0;
  logic [7:0] cfg_wdata_i = 8'h00;
  logic       cfg_lock_i = 1'b0;
  logic [7:0] cfg_rdata_o;
  logic       locked_o, cell_start_o, hec_err_o;

  int checks = 0, failures = 0, extra = 0;
  logic st_s, er_s, lk_s;
  logic [7:0] kk = 8'h00;

  cell_delin u_cell_delin (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(byte_i), .valid_i(valid_i),
    .cfg_we_i(cfg_we_i), .cfg_wdata_i(cfg_wdata_i), .cfg_lock_i(cfg_lock_i),
    .cfg_rdata_o(cfg_rdata_o), .locked_o(locked_o),
    .cell_start_o(cell_start_o), .hec_err_o(hec_err_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // bytewise CRC form, independent of the RTL
  function automatic logic [7:0] ref_hec(input logic [7:0] b0, b1, b2, b3);
    logic [7:0] c;
    logic [7:0] bs [4];
    bs = '{b0, b1, b2, b3};
    c = 8'h00;
    for (int j = 0; j < 4; j++) begin
      c = c ^ bs[j];
      for (int s = 0; s < 8; s++) c = c[7] ? ((c << 1) ^ 8'h07) : (c << 1);
    end
    return c ^ 8'h55;
  endfunction

  // header 00 00 00 k; reject k whose windows against zero payload could match in hunt
  function automatic logic clean(input logic [7:0] k);
    logic [7:0] x;
    if (k == 8'h55 || k == 8'h00) return 1'b0;
    for (int v = 0; v < 2; v++) begin
      x = ref_hec(8'h00, 8'h00, 8'h00, k) ^ (v == 1 ? 8'hFF : 8'h00);
      if (ref_hec(8'h00, 8'h00, k, x) == 8'h00) return 1'b0;
      if (ref_hec(8'h00, k, x, 8'h00) == 8'h00) return 1'b0;
      if (ref_hec(k, x, 8'h00, 8'h00) == 8'h00) return 1'b0;
      if (ref_hec(x, 8'h00, 8'h00, 8'h00) == 8'h00) return 1'b0;
    end
    return 1'b1;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk_i);
    byte_i = b; valid_i = 1'b1;
    @(posedge clk_i); #1;
  endtask

  task automatic idle();
    @(negedge clk_i);
    byte_i = 8'hC3; valid_i = 1'b0;
    @(posedge clk_i); #1;
  endtask

  task automatic send_cell(input logic bad, input logic gaps);
    logic [7:0] h;
    do kk = kk + 8'd1; while (!clean(kk));
    h = ref_hec(8'h00, 8'h00, 8'h00, kk) ^ (bad ? 8'hFF : 8'h00);
    for (int i = 0; i < 53; i++) begin
      if (gaps && (i % 7 == 2)) begin
        idle();
        if (cell_start_o || hec_err_o) extra++;
      end
      send_byte(i == 3 ? kk : (i == 4 ? h : 8'h00));
      if (i == 4) begin
        st_s = cell_start_o; er_s = hec_err_o; lk_s = locked_o;
      end else if (cell_start_o || hec_err_o) extra++;
    end
  endtask

  task automatic cfg_write(input logic we, input logic lk, input logic [7:0] d);
    @(negedge clk_i);
    cfg_we_i = we; cfg_lock_i = lk; cfg_wdata_i = d; valid_i = 1'b0;
    @(posedge clk_i); #1;
    @(negedge clk_i);
    cfg_we_i = 1'b0; cfg_lock_i = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;
    #1;
    check("R2 reset threshold", cfg_rdata_o, 8'h78);
    check("R6 reset unlocked", locked_o, 0);
    check("R10 R11 reset pulses", {cell_start_o, hec_err_o}, 0);

    // R1 R4 R6 default gain 8: hunt match on cell 1, lock on cell 9
    send_cell(1'b0, 1'b0);
    check("R4 hunt match no err", er_s, 0);
    for (int c = 2; c <= 8; c++) send_cell(1'b0, 1'b0);
    check("R6 not locked after 8 cells", lk_s, 0);
    send_cell(1'b0, 1'b0);
    check("R1 R6 locked on cell 9", lk_s, 1);
    check("R10 no start on lock cell", st_s, 0);
    send_cell(1'b0, 1'b0);
    check("R10 start while locked", st_s, 1);

    // R3 register vector table
    foreach (CFG_VEC[v]) begin
      cfg_write(CFG_VEC[v][17], CFG_VEC[v][16], CFG_VEC[v][15:8]);
      check("R3 threshold write", cfg_rdata_o, int'(CFG_VEC[v][7:0]));
    end
    check("R2 lock kept during writes", locked_o, 1);

    // loss 3, gain 2
    send_cell(1'b1, 1'b0);
    check("R11 err in sync", er_s, 1);
    send_cell(1'b1, 1'b0);
    check("R7 still locked after 2 bad", lk_s, 1);
    check("R10 start on bad header", st_s, 1);
    send_cell(1'b0, 1'b0);
    check("R8 good header no err", er_s, 0);
    send_cell(1'b1, 1'b0);
    send_cell(1'b1, 1'b0);
    check("R8 count cleared, still locked", lk_s, 1);
    send_cell(1'b1, 1'b0);
    check("R7 lock lost on 3rd bad", lk_s, 0);
    check("R11 err on losing header", er_s, 1);

    // reacquire with gain 2
    send_cell(1'b0, 1'b0);
    check("R4 hunt entry silent", {st_s, er_s, lk_s}, 0);
    send_cell(1'b0, 1'b0);
    check("R6 pre-lock 1 good", lk_s, 0);
    send_cell(1'b0, 1'b0);
    check("R6 locked after 2 good", lk_s, 1);

    // R5 bad header in pre-lock
    for (int c = 0; c < 3; c++) send_cell(1'b1, 1'b0);
    check("R7 lost again", lk_s, 0);
    send_cell(1'b0, 1'b0);
    send_cell(1'b1, 1'b0);
    check("R5 pre-lock err pulse", er_s, 1);
    send_cell(1'b0, 1'b0);
    check("R5 back to hunt, silent", er_s, 0);
    send_cell(1'b0, 1'b0);
    check("R5 not yet locked", lk_s, 0);
    send_cell(1'b0, 1'b0);
    check("R5 relocked after hunt", lk_s, 1);

    // R12 idle gaps with garbage bytes
    for (int c = 0; c < 3; c++) send_cell(1'b1, 1'b1);
    check("R12 lost with gaps", lk_s, 0);
    for (int c = 0; c < 3; c++) send_cell(1'b0, 1'b1);
    check("R12 locked with gaps", lk_s, 1);
    send_cell(1'b0, 1'b1);
    check("R12 start aligned with gaps", {st_s, er_s}, 2);

    // R9 zero thresholds act as 1
    cfg_write(1'b1, 1'b0, 8'h00);
    check("R9 reg reads zero", cfg_rdata_o, 8'h00);
    send_cell(1'b1, 1'b0);
    check("R9 loss of 1", lk_s, 0);
    send_cell(1'b0, 1'b0);
    check("R9 hunt entry", lk_s, 0);
    send_cell(1'b0, 1'b0);
    check("R9 gain of 1", lk_s, 1);

    idle();
    check("R10 R11 no stray pulses", extra, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule